// File: doc/BRIEF.md
# Negotiated Low SMRAM Window Guard

This block owns one byte-wide feature register and sits on the path between a memory requester and RAM. It guards a fixed low-memory window that starts at address 0x30000. Software turns the protection on in two steps. A negotiation write of 0xFF arms the feature. A later write of 0x02 seals it. From then on the register no longer changes. Ordinary reads of the window return 0xFF, and ordinary writes to it never reach RAM. This holds until the system reset input is asserted. The block never resets RAM, so the data stored in the window is visible again after a reset.

The block has four interfaces:
- a byte configuration port (write strobe, write data, read-back);
- a byte memory request port, with a one-cycle read response;
- the matching request and response port towards RAM;
- the clock and active-low reset.

A build parameter selects a legacy variant. In that variant the register is a plain storage byte and the memory path is never filtered.

Top module: `smram_base_guard`

## Requirements
- R1: After reset the configuration read-back is 0x00, and accesses to the window are forwarded to RAM.
- R2: While the register reads 0x00, a configuration write of any value 0x00..0xFE leaves it reading 0x00.
- R3: While the register reads 0x00, a write of 0xFF makes it read 0x01 from the cycle after the write.
- R4: While the register reads 0x01, a write of 0x02 makes it read 0x02 from the cycle after the write. Any other value leaves it at 0x01.
- R5: While the register reads 0x02, a configuration write of any value 0x00..0xFF leaves it reading 0x02.
- R6: While the register reads 0x02, a request inside the window is not forwarded (ram_req_valid stays 0 in that cycle). A read there returns 0xFF on the response.
- R7: The window is [BASE_ADDR, BASE_ADDR + WIN_BYTES), with defaults 0x30000 and 128 KB. A request outside it is always forwarded unchanged, even when the register reads 0x02.
- R8: While the register reads 0x01, requests inside the window are still forwarded, and reads return RAM data.
- R9: Asserting reset returns the register to 0x00 and lifts the block. RAM in the window then reads the bytes it held before the seal.
- R10: With LEGACY=1 the register stores and returns every written byte, and no request is ever withheld from RAM.
- R11: A read request raises mem_rsp_valid exactly one cycle later, with the data for that read. A write request produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_data | input | 8 | Configuration write value |
| cfg_rd_data | output | 8 | Current register value |
| mem_req_valid | input | 1 | Memory request present |
| mem_req_we | input | 1 | 1 = write, 0 = read |
| mem_req_addr | input | ADDR_W | Byte address of the request |
| mem_req_wdata | input | 8 | Write data |
| mem_rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| mem_rsp_rdata | output | 8 | Read data, or 0xFF when the read was blocked |
| ram_req_valid | output | 1 | Request forwarded to RAM |
| ram_req_we | output | 1 | Forwarded write flag |
| ram_req_addr | output | ADDR_W | Forwarded address |
| ram_req_wdata | output | 8 | Forwarded write data |
| ram_rsp_rdata | input | 8 | RAM read data, one cycle after a forwarded read |

## Verification
The bench builds two instances. Both use a 20-bit address, base 0x30000 and a 128 KB window, so the accesses at 0x2FFFF, 0x30000, 0x4FFFF and 0x50000 probe both window edges. The first instance uses LEGACY=0 and walks the full negotiate, seal and reset sequence, with exhaustive configuration-value sweeps in the open and sealed states. The second uses LEGACY=1, which brings the plain-byte variant and the unfiltered memory path within reach on the same stimulus.

// File: rtl/smbg_pkg.sv
package smbg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] NEGOTIATE_CODE = 8'hFF;
  localparam logic [BYTE_W-1:0] SEAL_CODE      = 8'h02;
  localparam logic [BYTE_W-1:0] HOLE_BYTE      = 8'hFF;

  // State value equals the byte seen on the read-back port.
  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_ARMED  = 2'd1,
    GS_SEALED = 2'd2
  } guard_state_e;

  function automatic guard_state_e guard_next(input guard_state_e cur,
                                              input logic wr,
                                              input logic [BYTE_W-1:0] val);
    guard_state_e nxt;
    nxt = cur;
    if (wr) begin
      unique case (cur)
        GS_IDLE:   if (val == NEGOTIATE_CODE) nxt = GS_ARMED;
        GS_ARMED:  if (val == SEAL_CODE)      nxt = GS_SEALED;
        default:   nxt = cur;
      endcase
    end
    return nxt;
  endfunction

  function automatic logic [BYTE_W-1:0] guard_readback(input guard_state_e st);
    return {6'b0, st};
  endfunction

  function automatic logic addr_in_window(input logic [31:0] addr,
                                          input logic [31:0] base,
                                          input logic [31:0] len);
    return (addr >= base) && ((addr - base) < len);
  endfunction

endpackage

// File: rtl/smbg_cfg_reg.sv
module smbg_cfg_reg
  import smbg_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              seal_active
);

  generate
    if (LEGACY) begin : g_plain
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     byte_q <= '0;
        else if (wr_en) byte_q <= wr_data;
      end
      assign rd_data     = byte_q;
      assign seal_active = 1'b0;
    end else begin : g_guard
      guard_state_e st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GS_IDLE;
        else        st_q <= guard_next(st_q, wr_en, wr_data);
      end
      assign rd_data     = guard_readback(st_q);
      assign seal_active = (st_q == GS_SEALED);
    end
  endgenerate

endmodule

// File: rtl/smbg_win_decode.sv
module smbg_win_decode
  import smbg_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h30000,
  parameter int unsigned     WIN_BYTES = 32'd131072
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [31:0] BASE32 = 32'(BASE_ADDR);
  localparam logic [31:0] LEN32  = 32'(WIN_BYTES);

  assign hit = addr_in_window(32'(addr), BASE32, LEN32);

endmodule

// File: rtl/smbg_mem_gate.sv
module smbg_mem_gate
  import smbg_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              win_hit,
  input  logic              seal_active,
  output logic              ram_valid,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              block_now
);

  logic rsp_valid_q;
  logic rsp_hole_q;

  assign block_now = req_valid && win_hit && seal_active;

  assign ram_valid = req_valid && !block_now;
  assign ram_we    = req_we && !block_now;
  assign ram_addr  = req_addr;
  assign ram_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hole_q  <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid && !req_we;
      rsp_hole_q  <= block_now && !req_we;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_hole_q ? HOLE_BYTE : ram_rdata;

endmodule

// File: rtl/smram_base_guard.sv
module smram_base_guard
  import smbg_pkg::*;
#(
  parameter bit                LEGACY    = 1'b0,
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h30000,
  parameter int unsigned       WIN_BYTES = 32'd131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_data,
  output logic [7:0]        cfg_rd_data,
  input  logic              mem_req_valid,
  input  logic              mem_req_we,
  input  logic [ADDR_W-1:0] mem_req_addr,
  input  logic [7:0]        mem_req_wdata,
  output logic              mem_rsp_valid,
  output logic [7:0]        mem_rsp_rdata,
  output logic              ram_req_valid,
  output logic              ram_req_we,
  output logic [ADDR_W-1:0] ram_req_addr,
  output logic [7:0]        ram_req_wdata,
  input  logic [7:0]        ram_rsp_rdata
);

  // Named internal events, brought out for the bound checker.
  logic win_hit_w;
  logic seal_active_w;
  logic block_now_w;

  smbg_cfg_reg #(.LEGACY(LEGACY)) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr_en),
    .wr_data     (cfg_wr_data),
    .rd_data     (cfg_rd_data),
    .seal_active (seal_active_w)
  );

  smbg_win_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .WIN_BYTES (WIN_BYTES)
  ) dec_i (
    .addr (mem_req_addr),
    .hit  (win_hit_w)
  );

  smbg_mem_gate #(.ADDR_W(ADDR_W)) gate_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (mem_req_valid),
    .req_we      (mem_req_we),
    .req_addr    (mem_req_addr),
    .req_wdata   (mem_req_wdata),
    .win_hit     (win_hit_w),
    .seal_active (seal_active_w),
    .ram_valid   (ram_req_valid),
    .ram_we      (ram_req_we),
    .ram_addr    (ram_req_addr),
    .ram_wdata   (ram_req_wdata),
    .ram_rdata   (ram_rsp_rdata),
    .rsp_valid   (mem_rsp_valid),
    .rsp_rdata   (mem_rsp_rdata),
    .block_now   (block_now_w)
  );

endmodule

// File: rtl/smram_base_guard_chk.sv
module smram_base_guard_chk #(
  parameter bit LEGACY = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_wr_data,
  input logic [7:0] cfg_rd_data,
  input logic       mem_req_valid,
  input logic       mem_req_we,
  input logic       mem_rsp_valid,
  input logic [7:0] mem_rsp_rdata,
  input logic       ram_req_valid,
  input logic       win_hit,
  input logic       seal_active
);

  p_rsp_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |=> mem_rsp_valid);

  p_no_rsp_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mem_req_valid && !mem_req_we)) |=> !mem_rsp_valid);

  p_outside_forwarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !win_hit) |-> ram_req_valid);

  generate
    if (LEGACY) begin : g_leg
      p_plain_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (cfg_rd_data == $past(cfg_wr_data)));

      p_never_withheld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ram_req_valid);
    end else begin : g_grd
      p_legal_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 8'h00) || (cfg_rd_data == 8'h01) || (cfg_rd_data == 8'h02));

      p_idle_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 8'h00 && !(cfg_wr_en && cfg_wr_data == 8'hFF)) |=> (cfg_rd_data == 8'h00));

      p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 8'h00 && cfg_wr_en && cfg_wr_data == 8'hFF) |=> (cfg_rd_data == 8'h01));

      p_sealed_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 8'h02) |=> (cfg_rd_data == 8'h02));

      p_sealed_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_active && mem_req_valid && win_hit) |-> !ram_req_valid);

      p_hole_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_active && mem_req_valid && !mem_req_we && win_hit) |=> (mem_rsp_rdata == 8'hFF));

      p_armed_forwards_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 8'h01 && mem_req_valid) |-> ram_req_valid);
    end
  endgenerate

endmodule

bind smram_base_guard smram_base_guard_chk #(.LEGACY(LEGACY)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_wr_data   (cfg_wr_data),
  .cfg_rd_data   (cfg_rd_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_rdata (mem_rsp_rdata),
  .ram_req_valid (ram_req_valid),
  .win_hit       (win_hit_w),
  .seal_active   (seal_active_w)
);

// File: tb/smram_base_guard_tb_top.sv
`timescale 1ns/1ps
module smram_base_guard_tb_top;

  localparam int AW = 20;
  localparam logic [31:0] WBASE = 32'h30000;
  localparam logic [31:0] WLEN  = 32'h20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Guarded instance (A) and legacy instance (B).
  logic          a_cwe = 0, b_cwe = 0;
  logic [7:0]    a_cwd = 0, b_cwd = 0;
  logic [7:0]    a_crd, b_crd;
  logic          a_mv = 0, b_mv = 0;
  logic          a_mwe = 0, b_mwe = 0;
  logic [AW-1:0] a_ma = 0, b_ma = 0;
  logic [7:0]    a_mwd = 0, b_mwd = 0;
  logic          a_rv, b_rv;
  logic [7:0]    a_rd, b_rd;
  logic          a_qv, b_qv;
  logic          a_qwe, b_qwe;
  logic [AW-1:0] a_qa, b_qa;
  logic [7:0]    a_qwd, b_qwd;
  logic [7:0]    a_qrd, b_qrd;

  logic [7:0] ram_a [1024];
  logic [7:0] ram_b [1024];
  logic [7:0] exp_a [1024];
  logic [7:0] exp_b [1024];
  logic [7:0] a_reg_exp = 8'h00;

  smram_base_guard #(.LEGACY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(a_cwe), .cfg_wr_data(a_cwd), .cfg_rd_data(a_crd),
    .mem_req_valid(a_mv), .mem_req_we(a_mwe), .mem_req_addr(a_ma), .mem_req_wdata(a_mwd),
    .mem_rsp_valid(a_rv), .mem_rsp_rdata(a_rd),
    .ram_req_valid(a_qv), .ram_req_we(a_qwe), .ram_req_addr(a_qa), .ram_req_wdata(a_qwd),
    .ram_rsp_rdata(a_qrd));

  smram_base_guard #(.LEGACY(1'b1)) dut_leg_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(b_cwe), .cfg_wr_data(b_cwd), .cfg_rd_data(b_crd),
    .mem_req_valid(b_mv), .mem_req_we(b_mwe), .mem_req_addr(b_ma), .mem_req_wdata(b_mwd),
    .mem_rsp_valid(b_rv), .mem_rsp_rdata(b_rd),
    .ram_req_valid(b_qv), .ram_req_we(b_qwe), .ram_req_addr(b_qa), .ram_req_wdata(b_qwd),
    .ram_rsp_rdata(b_qrd));

  // RAM models: one-cycle read latency, never reset.
  always @(posedge clk) begin
    if (a_qv) begin
      if (a_qwe) ram_a[a_qa[9:0]] <= a_qwd;
      else       a_qrd <= ram_a[a_qa[9:0]];
    end
    if (b_qv) begin
      if (b_qwe) ram_b[b_qa[9:0]] <= b_qwd;
      else       b_qrd <= ram_b[b_qa[9:0]];
    end
  end

  function automatic bit tb_in_win(input logic [AW-1:0] ad);
    logic [31:0] x;
    x = {12'd0, ad};
    return (x >= WBASE) && (x < WBASE + WLEN);
  endfunction

  function automatic logic [7:0] tb_next_reg(input logic [7:0] cur, input logic [7:0] v);
    if (cur == 8'h00 && v == 8'hFF) return 8'h01;
    if (cur == 8'h01 && v == 8'h02) return 8'h02;
    return cur;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic a_cfg(input logic [7:0] v, input string req);
    a_cwe = 1'b1; a_cwd = v;
    tick();
    a_cwe = 1'b0;
    a_reg_exp = tb_next_reg(a_reg_exp, v);
    check(req, {24'd0, a_crd}, {24'd0, a_reg_exp});
  endtask

  task automatic a_write(input logic [AW-1:0] ad, input logic [7:0] d, input string req);
    bit fwd;
    fwd = !(a_reg_exp == 8'h02 && tb_in_win(ad));
    a_mv = 1'b1; a_mwe = 1'b1; a_ma = ad; a_mwd = d;
    #1;
    check(req, {31'd0, a_qv}, {31'd0, fwd});
    tick();
    a_mv = 1'b0; a_mwe = 1'b0;
    if (fwd) exp_a[ad[9:0]] = d;
    check("R11", {31'd0, a_rv}, 32'd0);
  endtask

  task automatic a_read(input logic [AW-1:0] ad, input string req);
    bit fwd;
    logic [7:0] e;
    fwd = !(a_reg_exp == 8'h02 && tb_in_win(ad));
    e = fwd ? exp_a[ad[9:0]] : 8'hFF;
    a_mv = 1'b1; a_mwe = 1'b0; a_ma = ad;
    #1;
    check(req, {31'd0, a_qv}, {31'd0, fwd});
    tick();
    a_mv = 1'b0;
    check("R11", {31'd0, a_rv}, 32'd1);
    check(req, {24'd0, a_rd}, {24'd0, e});
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    a_reg_exp = 8'h00;
    tick();
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      ram_a[i] = 8'h00; exp_a[i] = 8'h00;
      ram_b[i] = 8'h00; exp_b[i] = 8'h00;
    end
    a_qrd = 8'h00; b_qrd = 8'h00;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1", {24'd0, a_crd}, 32'h00);
    a_write(20'h30000, 8'h32, "R1");
    a_read(20'h30000, "R1");

    // R2: junk before negotiation ignored
    for (int v = 0; v < 255; v++) a_cfg(8'(v), "R2");

    // R3: negotiation
    a_cfg(8'hFF, "R3");
    check("R3", {24'd0, a_crd}, 32'h01);

    // R4: other values ignored while armed
    a_cfg(8'h00, "R4");
    a_cfg(8'h55, "R4");
    a_cfg(8'hFF, "R4");
    check("R4", {24'd0, a_crd}, 32'h01);

    // R8: armed window still reaches RAM
    a_write(20'h30010, 8'h44, "R8");
    a_read(20'h30010, "R8");
    a_read(20'h30000, "R8");

    // R4: seal
    a_cfg(8'h02, "R4");
    check("R4", {24'd0, a_crd}, 32'h02);

    // R5: every value ignored once sealed, R6 black hole in between
    for (int v = 0; v < 256; v++) begin
      a_cfg(8'(v), "R5");
      if (v % 32 == 0) begin
        a_write(20'h30000, 8'h32 + 8'(v), "R6");
        a_read(20'h30000, "R6");
      end
    end

    // R7: window edges
    a_write(20'h2FFFF, 8'hA1, "R7");
    a_read(20'h2FFFF, "R7");
    a_read(20'h30000, "R6");
    a_write(20'h4FFFF, 8'hB2, "R6");
    a_read(20'h4FFFF, "R6");
    a_write(20'h50000, 8'hC3, "R7");
    a_read(20'h50000, "R7");

    // Random mix around the window while sealed (R6, R7, R11)
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] ad;
      ad = 20'h2F000 + 20'($urandom_range(0, 32'h22000));
      if ($urandom_range(0, 1) == 1) a_write(ad, 8'($urandom), "R7");
      else                           a_read(ad, "R7");
    end

    // R9: reset lifts the block, old content visible
    do_reset();
    check("R9", {24'd0, a_crd}, 32'h00);
    a_read(20'h30000, "R9");
    a_write(20'h30000, 8'h23, "R9");
    a_read(20'h30000, "R9");
    a_cfg(8'h02, "R9");

    // R10: legacy instance is a plain byte, never blocks
    for (int v = 0; v < 256; v++) begin
      b_cwe = 1'b1; b_cwd = 8'(v);
      tick();
      b_cwe = 1'b0;
      check("R10", {24'd0, b_crd}, v);
    end
    b_cwe = 1'b1; b_cwd = 8'hFF; tick();
    b_cwd = 8'h02; tick();
    b_cwe = 1'b0;
    check("R10", {24'd0, b_crd}, 32'h02);
    b_mv = 1'b1; b_mwe = 1'b1; b_ma = 20'h30000; b_mwd = 8'h5A;
    #1;
    check("R10", {31'd0, b_qv}, 32'd1);
    tick();
    b_mwe = 1'b0;
    #1;
    check("R10", {31'd0, b_qv}, 32'd1);
    tick();
    b_mv = 1'b0;
    check("R10", {31'd0, b_rv}, 32'd1);
    check("R10", {24'd0, b_rd}, 32'h5A);

    done = 1'b1;
    report();
  end

endmodule